// File: doc/BRIEF.md
# Phase Slope Verification Unit

This unit decides whether a phase-versus-delay curve has the wanted slope sign around a candidate delay setting. A search controller hands it a candidate delay, a target phase and the required slope direction, then pulses `start`. The unit drives the delay line itself. It takes one reference phase at the candidate, then walks the delay upward one code per accepted phase sample until a stop event occurs. It goes back to the candidate and walks downward in the same way until a stop event occurs.

A walk stops when any of these holds: the phase has moved two codes from the reference, the phase sits at its ceiling or at zero, or the delay has reached the end of the line in the direction of travel. The phases at the two walk ends are then judged against the target. The slope is accepted only when the two end phases lie strictly on opposite sides of the target, in the order the requested sign demands. On completion the delay output is parked back on the candidate and a one-cycle `done` carries the verdict and the measured direction. The phase comparator that produces the samples is outside this block.

Top module: `phase_slope_check`

## Requirements
- R1: After synchronous reset, `dly_out` is 0, and `busy`, `done`, `slope_ok` and `slope_dir` are 0.
- R2: A `start` seen while idle latches `cand_in`, `tgt_ph`, `want_pos`. On the next cycle `busy` is 1 and `dly_out` equals the candidate, and `hold_dly` reports the latched candidate.
- R3: During the upward walk, `dly_out` rises by exactly 1 after each accepted sample (`ph_vld` high) and never exceeds `DLY_MAX` (default 431).
- R4: A walk stops at the first evaluated point where the phase differs from the reference phase (the sample taken at the candidate) by at least `PH_STEP` (default 2), or the phase is ≥ `PH_MAX` (default 16), or the phase is 0, or the delay equals `DLY_MAX` (upward walk) or 0 (downward walk). The reference point itself is evaluated first, so a walk may stop with no step at all.
- R5: The downward walk starts again from the candidate with the same reference phase and lowers `dly_out` by 1 per accepted sample, never below 0.
- R6: When both walks have ended, `done` is high for exactly one cycle with `busy` low and `dly_out` equal to the candidate. `dly_out` stays there until the next accepted `start`.
- R7: `slope_ok` is 1 when `want_pos`=1, the upward end phase is greater than `tgt_ph` and the downward end phase is less than it. It is also 1 when `want_pos`=0 and both comparisons are reversed. In every other case it is 0, including when either end phase equals the target. The value is valid with `done` and held until the next completion.
- R8: `slope_dir` is 1 when the upward end phase is greater than the downward end phase, else 0. It is valid with `done`.
- R9: A `start` while `busy` is 1 is ignored. The candidate, the walk and the verdict are those of the run already in progress.
- R10: While the unit waits for a sample and `ph_vld` is 0, `dly_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; accepted only while idle |
| cand_in | input | DLY_W | Candidate delay code |
| tgt_ph | input | PH_W | Target phase code |
| want_pos | input | 1 | 1: positive slope required, 0: negative |
| ph_meas | input | PH_W | Measured phase for the current `dly_out` |
| ph_vld | input | 1 | `ph_meas` is valid this cycle |
| dly_out | output | DLY_W | Delay code driven to the delay line |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| slope_ok | output | 1 | Slope verdict |
| slope_dir | output | 1 | Measured direction: up end above down end |
| hold_dly | output | DLY_W | Latched candidate delay |

## Verification
The bench uses the default parameters: a 9-bit delay with its top end at 431, a 5-bit phase with ceiling 16, and a stop threshold of 2. With these values the candidates 0 and 431 put both delay-end stop conditions inside a short run. A flat phase curve forces full walks to both ends of the line. Rising, falling, steep and saturating curves drive the phase-change, ceiling and floor stops. The sample strobe is thinned at random and stalled on purpose, so the stepping is checked against irregular sample timing.

// File: rtl/pslope_pkg.sv
package pslope_pkg;

    localparam int PS_DLY_W   = 9;
    localparam int PS_DLY_MAX = 431;
    localparam int PS_PH_W    = 5;
    localparam int PS_PH_MAX  = 16;
    localparam int PS_PH_STEP = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_UP_EVAL,
        ST_UP_WAIT,
        ST_DN_EVAL,
        ST_DN_WAIT
    } pslope_state_e;

    typedef struct packed {
        logic ok;
        logic rising;
    } pslope_verdict_t;

    function automatic int ps_abs_diff(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pslope_stop_detect.sv
module pslope_stop_detect
    import pslope_pkg::*;
#(
    parameter int DLY_W   = PS_DLY_W,
    parameter int PH_W    = PS_PH_W,
    parameter int DLY_MAX = PS_DLY_MAX,
    parameter int PH_MAX  = PS_PH_MAX,
    parameter int PH_STEP = PS_PH_STEP,
    parameter bit UPWARD  = 1'b1
) (
    input  logic [DLY_W-1:0] dly,
    input  logic [PH_W-1:0]  ph,
    input  logic [PH_W-1:0]  ref_ph,
    output logic             stop
);

    localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(PH_MAX);
    localparam logic [PH_W-1:0]  PH_ZERO = '0;
    localparam logic [DLY_W-1:0] DLY_TOP = DLY_W'(DLY_MAX);

    logic moved;
    logic ph_edge;
    logic dly_edge;

    always_comb begin
        moved   = ps_abs_diff(int'(ph), int'(ref_ph)) >= PH_STEP;
        ph_edge = (ph >= PH_TOP) || (ph == PH_ZERO);
    end

    generate
        if (UPWARD) begin : g_top_end
            assign dly_edge = (dly >= DLY_TOP);
        end else begin : g_bottom_end
            assign dly_edge = (dly == '0);
        end
    endgenerate

    assign stop = moved || ph_edge || dly_edge;

endmodule

// File: rtl/pslope_judge.sv
module pslope_judge
    import pslope_pkg::*;
#(
    parameter int PH_W = PS_PH_W
) (
    input  logic [PH_W-1:0] up_end,
    input  logic [PH_W-1:0] dn_end,
    input  logic [PH_W-1:0] tgt,
    input  logic            want_pos,
    output pslope_verdict_t verdict
);

    logic straddle_pos;
    logic straddle_neg;

    always_comb begin
        straddle_pos   = (up_end > tgt) && (dn_end < tgt);
        straddle_neg   = (up_end < tgt) && (dn_end > tgt);
        verdict.ok     = want_pos ? straddle_pos : straddle_neg;
        verdict.rising = (up_end > dn_end);
    end

endmodule

// File: rtl/phase_slope_check.sv
module phase_slope_check
    import pslope_pkg::*;
#(
    parameter int DLY_W   = PS_DLY_W,
    parameter int PH_W    = PS_PH_W,
    parameter int DLY_MAX = PS_DLY_MAX,
    parameter int PH_MAX  = PS_PH_MAX,
    parameter int PH_STEP = PS_PH_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] cand_in,
    input  logic [PH_W-1:0]  tgt_ph,
    input  logic             want_pos,
    input  logic [PH_W-1:0]  ph_meas,
    input  logic             ph_vld,
    output logic [DLY_W-1:0] dly_out,
    output logic             busy,
    output logic             done,
    output logic             slope_ok,
    output logic             slope_dir,
    output logic [DLY_W-1:0] hold_dly
);

    localparam int              N_DIR   = 2;
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    pslope_state_e    state_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cand_q;
    logic [PH_W-1:0]  tgt_q;
    logic             want_q;
    logic [PH_W-1:0]  ref_q;
    logic [PH_W-1:0]  cur_q;
    logic [PH_W-1:0]  up_end_q;
    logic             done_q;
    pslope_verdict_t  verdict_q;
    pslope_verdict_t  verdict_c;
    logic [N_DIR-1:0] stop_c;

    // index 0: upward walk, index 1: downward walk
    generate
        for (genvar i = 0; i < N_DIR; i++) begin : g_stop
            pslope_stop_detect #(
                .DLY_W  (DLY_W),
                .PH_W   (PH_W),
                .DLY_MAX(DLY_MAX),
                .PH_MAX (PH_MAX),
                .PH_STEP(PH_STEP),
                .UPWARD (i == 0)
            ) stop_i (
                .dly   (dly_q),
                .ph    (cur_q),
                .ref_ph(ref_q),
                .stop  (stop_c[i])
            );
        end
    endgenerate

    pslope_judge #(.PH_W(PH_W)) judge_i (
        .up_end  (up_end_q),
        .dn_end  (cur_q),
        .tgt     (tgt_q),
        .want_pos(want_q),
        .verdict (verdict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dly_q     <= '0;
            cand_q    <= '0;
            tgt_q     <= '0;
            want_q    <= 1'b0;
            ref_q     <= '0;
            cur_q     <= '0;
            up_end_q  <= '0;
            done_q    <= 1'b0;
            verdict_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cand_q  <= cand_in;
                        tgt_q   <= tgt_ph;
                        want_q  <= want_pos;
                        dly_q   <= cand_in;
                        state_q <= ST_BASE;
                    end
                end
                ST_BASE: begin
                    if (ph_vld) begin
                        ref_q   <= ph_meas;
                        cur_q   <= ph_meas;
                        state_q <= ST_UP_EVAL;
                    end
                end
                ST_UP_EVAL: begin
                    if (stop_c[0]) begin
                        up_end_q <= cur_q;
                        cur_q    <= ref_q;
                        dly_q    <= cand_q;
                        state_q  <= ST_DN_EVAL;
                    end else begin
                        dly_q   <= dly_q + DLY_ONE;
                        state_q <= ST_UP_WAIT;
                    end
                end
                ST_UP_WAIT: begin
                    if (ph_vld) begin
                        cur_q   <= ph_meas;
                        state_q <= ST_UP_EVAL;
                    end
                end
                ST_DN_EVAL: begin
                    if (stop_c[1]) begin
                        verdict_q <= verdict_c;
                        dly_q     <= cand_q;
                        done_q    <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        dly_q   <= dly_q - DLY_ONE;
                        state_q <= ST_DN_WAIT;
                    end
                end
                ST_DN_WAIT: begin
                    if (ph_vld) begin
                        cur_q   <= ph_meas;
                        state_q <= ST_DN_EVAL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dly_out   = dly_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign slope_ok  = verdict_q.ok;
    assign slope_dir = verdict_q.rising;
    assign hold_dly  = cand_q;

endmodule

// File: rtl/pslope_checker.sv
module pslope_checker #(
    parameter int DLY_W   = 9,
    parameter int DLY_MAX = 431
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [DLY_W-1:0] cand_in,
    input logic [DLY_W-1:0] dly_out,
    input logic             busy,
    input logic             done,
    input logic [DLY_W-1:0] hold_dly
);

    assert_dly_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(dly_out) <= DLY_MAX);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (int'(dly_out) - int'($past(dly_out)) <= 1 &&
                  int'($past(dly_out)) - int'(dly_out) <= 1) || dly_out == hold_dly);

    assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && dly_out == $past(cand_in) && hold_dly == $past(cand_in)));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_parked_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && dly_out == hold_dly));

    assert_idle_rest_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dly_out));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(hold_dly));

endmodule

bind phase_slope_check pslope_checker #(
    .DLY_W  (DLY_W),
    .DLY_MAX(DLY_MAX)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cand_in (cand_in),
    .dly_out (dly_out),
    .busy    (busy),
    .done    (done),
    .hold_dly(hold_dly)
);

// File: tb/phase_slope_check_tb_top.sv
module phase_slope_check_tb_top;

    localparam int DW = 9;
    localparam int PW = 5;
    localparam int DMAX = 431;
    localparam int PMAX = 16;
    localparam int PSTEP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] cand_in = '0;
    logic [PW-1:0] tgt_ph = '0;
    logic          want_pos = 1'b0;
    logic [PW-1:0] ph_meas = '0;
    logic          ph_vld = 1'b0;
    logic [DW-1:0] dly_out;
    logic          busy, done, slope_ok, slope_dir;
    logic [DW-1:0] hold_dly;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int stall_n = 0;

    // phase curve: base + sgn*mul*(d-ctr)/div, clamped to 0..PMAX
    int c_base = 14, c_sgn = 1, c_mul = 1, c_ctr = 216, c_div = 12;

    always #2 clk = ~clk;

    phase_slope_check dut_i (
        .clk(clk), .rst(rst), .start(start), .cand_in(cand_in), .tgt_ph(tgt_ph),
        .want_pos(want_pos), .ph_meas(ph_meas), .ph_vld(ph_vld), .dly_out(dly_out),
        .busy(busy), .done(done), .slope_ok(slope_ok), .slope_dir(slope_dir),
        .hold_dly(hold_dly)
    );

    function automatic int phase_at(input int d);
        int v;
        v = c_base + (c_sgn * c_mul * (d - c_ctr)) / c_div;
        if (v < 0) v = 0;
        if (v > PMAX) v = PMAX;
        return v;
    endfunction

    function automatic bit ends_here(input int d, input int p, input int r, input bit up);
        int df;
        df = (p > r) ? p - r : r - p;
        return (df >= PSTEP) || (p >= PMAX) || (p == 0) || (up ? (d >= DMAX) : (d == 0));
    endfunction

    // phase source: reports the curve at the current delay, strobe thinned at random
    always @(negedge clk) begin
        ph_meas <= PW'(phase_at(int'(dly_out)));
        if (stall_n > 0) begin
            ph_vld  <= 1'b0;
            stall_n <= stall_n - 1;
        end else begin
            ph_vld <= (($urandom % 4) != 0);
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int cand, input int tgt, input bit want,
                            input bit poke, input int stall);
        int r, d, p, up_p, dn_p, hi, lo, last;
        bit exp_ok, exp_dir, seen, range_bad, stuck_bad;
        r = phase_at(cand);
        d = cand; p = r;
        while (!ends_here(d, p, r, 1'b1)) begin d++; p = phase_at(d); end
        up_p = p; hi = d;
        d = cand; p = r;
        while (!ends_here(d, p, r, 1'b0)) begin d--; p = phase_at(d); end
        dn_p = p; lo = d;
        exp_ok  = want ? (up_p > tgt && dn_p < tgt) : (up_p < tgt && dn_p > tgt);
        exp_dir = (up_p > dn_p);

        @(negedge clk);
        cand_in = DW'(cand); tgt_ph = PW'(tgt); want_pos = want; start = 1'b1;
        if (stall > 0) stall_n = stall + 1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(int'(dly_out) == cand, "R2 dly_out at candidate", int'(dly_out), cand);
        if (stall > 0) begin
            stuck_bad = 0;
            for (int k = 0; k < stall - 1; k++) begin
                @(negedge clk);
                if (int'(dly_out) != cand) stuck_bad = 1;
            end
            check(!stuck_bad, "R10 delay held while no sample", int'(dly_out), cand);
        end
        seen = 0; range_bad = 0; last = int'(dly_out);
        for (int n = 0; n < 4000 && !seen; n++) begin
            if (poke && n == 5) begin
                cand_in = DW'(cand ^ 9'h055); start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (busy && (int'(dly_out) > hi || int'(dly_out) < lo)) range_bad = 1;
            if (int'(dly_out) > DMAX) range_bad = 1;
            if (done) seen = 1;
        end
        check(seen, "R6 done reached", int'(seen), 1);
        check(!range_bad, "R3 R5 delay walk inside expected span", int'(dly_out), hi);
        check(!busy, "R6 busy low at done", int'(busy), 0);
        check(int'(dly_out) == cand, "R6 delay parked on candidate", int'(dly_out), cand);
        check(int'(hold_dly) == cand, "R9 candidate held", int'(hold_dly), cand);
        check(slope_ok == exp_ok, "R7 slope verdict", int'(slope_ok), int'(exp_ok));
        check(slope_dir == exp_dir, "R8 measured direction", int'(slope_dir), int'(exp_dir));
        @(negedge clk);
        check(!done, "R6 done is one cycle", int'(done), 0);
        check(int'(dly_out) == cand, "R6 delay stays parked", int'(dly_out), cand);
        check(slope_ok == exp_ok, "R7 verdict held", int'(slope_ok), int'(exp_ok));
    endtask

    task automatic set_curve(input int b, input int s, input int m, input int c, input int dv);
        c_base = b; c_sgn = s; c_mul = m; c_ctr = c; c_div = dv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dly_out == '0, "R1 reset delay", int'(dly_out), 0);
        check({busy, done, slope_ok, slope_dir} == 4'b0, "R1 reset flags",
              int'({busy, done, slope_ok, slope_dir}), 0);

        // rising curve, preferred target, positive wanted (R4 phase change / ceiling)
        set_curve(14, 1, 1, 216, 12);
        run_case(216, 14, 1'b1, 1'b0, 0);
        // same curve, negative wanted: rejected (R7)
        run_case(216, 14, 1'b0, 1'b0, 0);
        // target equals the upward end phase: rejected (R7)
        run_case(216, 16, 1'b1, 1'b0, 0);
        // falling curve, negative wanted (R7, R8)
        set_curve(9, -1, 1, 200, 10);
        run_case(200, 9, 1'b0, 1'b0, 0);
        // steep curve, one step each way (R4)
        set_curve(8, 1, 3, 100, 1);
        run_case(100, 8, 1'b1, 1'b0, 0);
        // top of the delay line, up walk stops at once (R4)
        set_curve(8, 1, 1, 400, 12);
        run_case(431, 9, 1'b1, 1'b0, 0);
        // bottom of the delay line, down walk stops at once (R4)
        set_curve(8, 1, 1, 30, 6);
        run_case(0, 4, 1'b1, 1'b0, 0);
        // flat curve: full walks to both ends, equal phases rejected (R3 R5 R7)
        set_curve(7, 1, 0, 0, 1);
        run_case(150, 7, 1'b1, 1'b0, 0);
        // start while busy ignored, plus stalled samples (R9, R10)
        set_curve(14, 1, 1, 216, 12);
        run_case(220, 14, 1'b1, 1'b1, 12);
        // floor stop on a falling curve (R4)
        set_curve(2, -1, 1, 50, 8);
        run_case(60, 1, 1'b0, 1'b0, 0);

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule